// File: doc/BRIEF.md
# Crossbar Element Permutation Unit

This block performs a table-lookup permutation across a scalar register value. The first operand is read as a small table of equal-width elements. Every element of the second operand holds an index into that table. Each result element is the table entry that its index selects. If the index points past the last entry, the result element is forced to zero; it does not wrap.

A one-bit select chooses the element width for each operation: 4-bit elements (nibble mode) or 8-bit elements (byte mode). Each width has its own fixed datapath, and the select picks between the two results. The word width is a parameter and may be 32 or 64.

The result is captured in a register on the clock edge at which the input strobe is high. The output strobe follows the input strobe one cycle later. While the input strobe is low, the register keeps its last value.

Top module: `xbar_perm_unit`

## Requirements
- R1: With `elem_sel`=0 (nibble mode), result nibble i equals nibble k of `opa`, where k is the value of nibble i of `opb` and k < XLEN/4. Nibble k occupies bits [4k+3:4k].
- R2: In nibble mode, a result nibble whose index is XLEN/4 or greater is 0000. This can only happen when XLEN is 32, for index values 8 to 15.
- R3: With `elem_sel`=1 (byte mode), result byte i equals byte k of `opa`, where k is the value of byte i of `opb` and k < XLEN/8. Byte k occupies bits [8k+7:8k].
- R4: In byte mode, a result byte whose index is XLEN/8 or greater is zero. For XLEN=32, any index of 4 or more gives a zero byte.
- R5: Each result element depends only on its own index element and on `opa`. Different element positions may select the same entry or different entries, in any mix, and may mix in-range with out-of-range indices.
- R6: The element width may change from one accepted operation to the next with no idle cycle between them.
- R7: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R8: `result` is loaded only at a rising edge with `in_valid`=1. At any other edge it keeps its value, whatever `opa`, `opb` and `elem_sel` do.
- R9: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| elem_sel | input | 1 | Element width: 0 selects 4 bits, 1 selects 8 bits |
| opa | input | XLEN | Lookup table operand |
| opb | input | XLEN | Index operand |
| out_valid | output | 1 | Result is valid (one cycle after `in_valid`) |
| result | output | XLEN | Registered permutation result |

## Verification
The assertions assume that `opa`, `opb` and `elem_sel` carry known values whenever `in_valid` is high. They also assume that reset is applied before the first operation. The bench meets both conditions: it drives every input to a defined value during reset and changes the inputs only on the falling clock edge. It biases about half of the random index operands toward small values, so that both the in-range and the zeroing paths are exercised in each mode.

// File: rtl/xbp_pkg.sv
package xbp_pkg;

   // element width select encoding
   typedef enum logic {
      XBP_ESZ_NIB  = 1'b0,
      XBP_ESZ_BYTE = 1'b1
   } xbp_esz_e;

   // log2 of element widths for the two fixed datapaths
   localparam int XBP_NIB_LOG2  = 2;
   localparam int XBP_BYTE_LOG2 = 3;

endpackage

// File: rtl/xbp_lane.sv
// One result element: selects an entry of the table operand by index,
// returning zero when the index is beyond the last entry.
module xbp_lane #(
   parameter int XLEN = 32,
   parameter int EW   = 4
) (
   input  logic [XLEN-1:0] tbl_vec,
   input  logic [EW-1:0]   idx,
   output logic [EW-1:0]   elem
);
   localparam int NENT = XLEN / EW;
   localparam int IW   = $clog2(NENT);

   if (IW > EW) begin : g_bad_iw
      $error("xbp_lane: table has more entries than an index can address");
   end

   logic [EW-1:0] entry [NENT];
   logic          past_end;

   for (genvar e = 0; e < NENT; e++) begin : g_entry
      assign entry[e] = tbl_vec[e*EW +: EW];
   end

   // index bits above the table address mark an out-of-range lookup
   if (IW < EW) begin : g_oor
      assign past_end = |idx[EW-1:IW];
   end else begin : g_full
      assign past_end = 1'b0;
   end

   assign elem = past_end ? '0 : entry[idx[IW-1:0]];

endmodule

// File: rtl/xbp_xbar.sv
// Fixed-width crossbar: one lookup lane per element position.
module xbp_xbar #(
   parameter int XLEN   = 32,
   parameter int LOG2EW = 2
) (
   input  logic [XLEN-1:0] tbl_vec,
   input  logic [XLEN-1:0] idx_vec,
   output logic [XLEN-1:0] perm
);
   localparam int EW    = 1 << LOG2EW;
   localparam int NLANE = XLEN / EW;

   if (XLEN % EW != 0) begin : g_bad_div
      $error("xbp_xbar: XLEN must be a multiple of the element width");
   end

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      xbp_lane #(
         .XLEN (XLEN),
         .EW   (EW)
      ) u_lane (
         .tbl_vec (tbl_vec),
         .idx     (idx_vec[i*EW +: EW]),
         .elem    (perm[i*EW +: EW])
      );
   end

endmodule

// File: rtl/xbar_perm_unit.sv
module xbar_perm_unit #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            elem_sel,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   output logic            out_valid,
   output logic [XLEN-1:0] result
);
   import xbp_pkg::*;

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("xbar_perm_unit: XLEN must be 32 or 64");
   end

   logic [XLEN-1:0] perm_nib;
   logic [XLEN-1:0] perm_byte;
   logic [XLEN-1:0] perm_sel;
   xbp_esz_e        esz;

   assign esz = xbp_esz_e'(elem_sel);

   xbp_xbar #(
      .XLEN   (XLEN),
      .LOG2EW (XBP_NIB_LOG2)
   ) u_xbar_nib (
      .tbl_vec (opa),
      .idx_vec (opb),
      .perm    (perm_nib)
   );

   xbp_xbar #(
      .XLEN   (XLEN),
      .LOG2EW (XBP_BYTE_LOG2)
   ) u_xbar_byte (
      .tbl_vec (opa),
      .idx_vec (opb),
      .perm    (perm_byte)
   );

   always_comb begin
      unique case (esz)
         XBP_ESZ_BYTE: perm_sel = perm_byte;
         default:      perm_sel = perm_nib;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= perm_sel;
         end
      end
   end

endmodule

// File: rtl/xbp_checker.sv
module xbp_checker #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            elem_sel,
   input logic [XLEN-1:0] opa,
   input logic [XLEN-1:0] opb,
   input logic            out_valid,
   input logic [XLEN-1:0] result
);
   localparam int NIB_N  = XLEN / 4;
   localparam int BYTE_N = XLEN / 8;

   AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);  // R7

   AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);  // R7

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));  // R8

   AST_NIB_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !elem_sel && opb == '0) |=> result == {NIB_N{$past(opa[3:0])}});  // R1

   AST_NIB_OOR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !elem_sel && int'(opb[3:0]) >= NIB_N) |=> result[3:0] == 4'h0);  // R2

   AST_BYTE_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && elem_sel && opb == '0) |=> result == {BYTE_N{$past(opa[7:0])}});  // R3

   AST_BYTE_OOR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && elem_sel && int'(opb[7:0]) >= BYTE_N) |=> result[7:0] == 8'h00);  // R4

   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && result == '0));  // R9

endmodule

bind xbar_perm_unit xbp_checker #(.XLEN(XLEN)) u_xbp_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .elem_sel  (elem_sel),
   .opa       (opa),
   .opb       (opb),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/xbar_perm_unit_tb_top.sv
module xbar_perm_unit_tb_top;
   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            in_valid;
   logic            elem_sel;
   logic [XLEN-1:0] opa;
   logic [XLEN-1:0] opb;
   logic            out_valid;
   logic [XLEN-1:0] result;

   int              n_cmp = 0;
   int              n_bad = 0;
   bit              done  = 1'b0;
   logic            exp_v;
   logic [XLEN-1:0] exp_r;

   always #5 clk = ~clk;

   xbar_perm_unit #(.XLEN(XLEN)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .elem_sel  (elem_sel),
      .opa       (opa),
      .opb       (opb),
      .out_valid (out_valid),
      .result    (result)
   );

   // behavioural lookup model, bit by bit
   function automatic logic [XLEN-1:0] ref_perm(input logic [XLEN-1:0] a,
                                                input logic [XLEN-1:0] b,
                                                input logic sel);
      int es;
      logic [XLEN-1:0] r;
      es = sel ? 8 : 4;
      r  = '0;
      for (int i = 0; i < XLEN / es; i++) begin
         int idx;
         idx = 0;
         for (int k = 0; k < es; k++) if (b[i*es+k]) idx += (1 << k);
         if (idx * es < XLEN)
            for (int k = 0; k < es; k++) r[i*es+k] = a[idx*es+k];
      end
      return r;
   endfunction

   task automatic compare(input string tag);
      n_cmp++;
      if (out_valid !== exp_v) begin
         n_bad++;
         $display("FAIL %s out_valid: actual=%b expected=%b", tag, out_valid, exp_v);
      end
      n_cmp++;
      if (result !== exp_r) begin
         n_bad++;
         $display("FAIL %s result: actual=%h expected=%h", tag, result, exp_r);
      end
   endtask

   // called at a falling edge; model advances at the rising edge
   task automatic step(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input logic sel, input logic v, input string tag);
      opa      = a;
      opb      = b;
      elem_sel = sel;
      in_valid = v;
      @(posedge clk);
      if (v) exp_r = ref_perm(a, b, sel);
      exp_v = v;
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R7 watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      elem_sel = 1'b0;
      opa      = 32'hDEAD_BEEF;
      opb      = '0;
      exp_v    = 1'b0;
      exp_r    = '0;
      repeat (3) @(negedge clk);
      compare("R9");
      // stimulus in reset must not load anything
      in_valid = 1'b1;
      @(negedge clk);
      compare("R9");
      in_valid = 1'b0;
      rst_n    = 1'b1;
      @(negedge clk);
      compare("R9");

      // nibble mode
      step(32'h9ABC_DEF1, 32'h7654_3210, 1'b0, 1'b1, "R1 identity");
      step(32'h1234_5678, 32'h0123_4567, 1'b0, 1'b1, "R1 reverse");
      step(32'hCAFE_F00D, 32'h0000_0000, 1'b0, 1'b1, "R1 broadcast");
      step(32'hFFFF_FFFF, 32'hFEDC_BA98, 1'b0, 1'b1, "R2 all out of range");
      step(32'h8765_4321, 32'h8F30_9A12, 1'b0, 1'b1, "R5 nibble mixed");

      // byte mode
      step(32'hA1B2_C3D4, 32'h0001_0203, 1'b1, 1'b1, "R3 byte reverse");
      step(32'hA1B2_C3D4, 32'h0303_0303, 1'b1, 1'b1, "R3 byte broadcast");
      step(32'hFFFF_FFFF, 32'h04FF_8005, 1'b1, 1'b1, "R4 byte out of range");
      step(32'h1122_3344, 32'h0307_0002, 1'b1, 1'b1, "R5 byte mixed");

      // back-to-back size change
      for (int j = 0; j < 6; j++)
         step(32'h0F1E_2D3C, 32'h0102_0301, j[0], 1'b1, "R6 alternate size");

      // idle cycles with moving operands must hold the result
      for (int j = 0; j < 5; j++)
         step($urandom, $urandom, j[0], 1'b0, "R8 hold");

      // random traffic in both modes
      for (int j = 0; j < 400; j++) begin
         logic [XLEN-1:0] b;
         b = $urandom;
         if (j % 2 == 0) b = b & 32'h1313_1313;
         step($urandom, b, 1'($urandom), ($urandom % 4) != 0, "R7 random");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule